// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small 8-bit processor built around one accumulator. It runs every instruction as a fixed chain of single-clock register transfers. The transfers move values between a program counter, a memory address register, a memory data register, an instruction register and the accumulator. A 32-word by 8-bit memory sits inside the block. The memory data register is the only path between that memory and the other registers.

Memory is filled through a simple write port, and only while the core is held in synchronous reset. When reset is released, the core runs from location 1: the program counter is cleared by reset and is incremented before the first fetch. Every visible register and the current transfer number are brought out as outputs, so the register transfers can be watched cycle by cycle.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, `pc`, `mar`, `mdr`, `ir` and `acc` are cleared to zero, `step` becomes 0, and `halted` and `carry` are cleared.
- R2: A write through `ld_en`/`ld_addr`/`ld_data` stores the word only when `rst` is high at that clock edge. When `rst` is low, the write has no effect on memory.
- R3: Step 0 increments `pc`. Step 1 copies `pc` into `mar`. Step 2 loads `mdr` with the memory word that `mar` selects. Step 3 copies `mdr` into `ir`. Exactly one step completes per clock.
- R4: Step 4 copies the low 5 bits of `ir` (the operand address) into `mar`. Step 5 loads `mdr` with the word that `mar` selects. After step 6 the core returns to step 0, so every non-halt instruction takes 7 clocks.
- R5: Opcode 3'b101 in `ir[7:5]` (load) copies `mdr` into `acc` at step 6 and leaves `carry` unchanged.
- R6: Opcode 3'b001 (add) adds `mdr` to `acc` modulo 256 at step 6. It sets `carry` to the bit that drops out of the 8-bit sum.
- R7: Opcode 3'b010 (store) loads `mdr` with `acc` at step 5 instead of reading memory. At step 6 it writes `mdr` to the location held in `mar`.
- R8: Opcode 3'b000 (halt) moves the core at step 4 to step value 7 and raises `halted`. From then on, every register stays frozen until reset.
- R9: The opcodes 3'b011, 3'b100, 3'b110 and 3'b111 take the full 7 clocks but change neither `acc`, `carry` nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables memory loading |
| ld_en | input | 1 | Memory load strobe, effective only during reset |
| ld_addr | input | 5 | Memory load address |
| ld_data | input | 8 | Memory load data |
| pc | output | 5 | Program counter |
| mar | output | 5 | Memory address register |
| mdr | output | 8 | Memory data register |
| ir | output | 8 | Instruction register (opcode in bits 7:5, address in 4:0) |
| acc | output | 8 | Accumulator |
| step | output | 3 | Current transfer: 0 to 6 in sequence, 7 when halted |
| halted | output | 1 | Set after a halt instruction |
| carry | output | 1 | Carry out of the last add |

## Verification
The assertions assume that the load port is used only during reset. When the core is running, any write on that port must be ignored, not merged into the transfer chain. They also assume that reset lasts at least one clock edge before the core runs. The random programs keep their operand addresses in the upper half of memory, so stores never overwrite code. Every program ends in a halt word, so the core never runs off into data words. One deliberate write during a running add checks that the load port stays inert.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic [2:0]    step,
  output logic          halted,
  output logic          carry
);
  localparam int DEPTH = 1 << AW;
  localparam int OPW   = DW - AW;
  localparam logic [OPW-1:0] OP_HLT = OPW'(0);
  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_ST  = OPW'(2);
  localparam logic [OPW-1:0] OP_LD  = OPW'(5);
  localparam logic [2:0] S_INC = 3'd0, S_P2M = 3'd1, S_RD1 = 3'd2, S_IR = 3'd3,
                         S_ADR = 3'd4, S_RD2 = 3'd5, S_EXE = 3'd6, S_HLT = 3'd7;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd;
  logic [OPW-1:0] op;
  logic [DW:0] sum;

  assign rd  = mem[mar];
  assign op  = ir[DW-1:AW];
  assign sum = {1'b0, acc} + {1'b0, mdr};

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_en) mem[ld_addr] <= ld_data;
    end else if (step == S_EXE && op == OP_ST) begin
      mem[mar] <= mdr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0; acc <= '0;
      step <= S_INC; halted <= 1'b0; carry <= 1'b0;
    end else begin
      case (step)
        S_INC: begin pc <= pc + 1'b1; step <= S_P2M; end
        S_P2M: begin mar <= pc; step <= S_RD1; end
        S_RD1: begin mdr <= rd; step <= S_IR; end
        S_IR:  begin ir <= mdr; step <= S_ADR; end
        S_ADR: begin
          if (op == OP_HLT) begin
            step <= S_HLT; halted <= 1'b1;
          end else begin
            mar <= ir[AW-1:0]; step <= S_RD2;
          end
        end
        S_RD2: begin mdr <= (op == OP_ST) ? acc : rd; step <= S_EXE; end
        S_EXE: begin
          if (op == OP_LD) acc <= mdr;
          else if (op == OP_ADD) begin acc <= sum[DW-1:0]; carry <= sum[DW]; end
          step <= S_INC;
        end
        default: ;
      endcase
    end
  end

  p_pc_inc_r3: assert property (@(posedge clk) disable iff (rst)
    step == S_INC |=> pc == AW'($past(pc) + 1'b1));
  p_ir_from_mdr_r3: assert property (@(posedge clk) disable iff (rst)
    step == S_IR |=> ir == $past(mdr));
  p_mar_operand_r4: assert property (@(posedge clk) disable iff (rst)
    (step == S_ADR && op != OP_HLT) |=> mar == $past(ir[AW-1:0]));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    step == S_EXE |=> step == S_INC);
  p_store_mdr_r7: assert property (@(posedge clk) disable iff (rst)
    (step == S_RD2 && op == OP_ST) |=> mdr == $past(acc));
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(acc) && $stable(mar) && $stable(mdr) && step == S_HLT);
  p_acc_only_exe_r9: assert property (@(posedge clk) disable iff (rst)
    step != S_EXE |=> $stable(acc) && $stable(carry));
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  logic clk = 1'b0, rst = 1'b1, ld_en = 1'b0;
  logic [4:0] ld_addr = '0, pc, mar;
  logic [7:0] ld_data = '0, mdr, ir, acc;
  logic [2:0] step;
  logic halted, carry;
  int checks = 0, failures = 0;
  logic [7:0] m [32];
  logic [7:0] ma;
  logic mc;

  always #5 clk = ~clk;

  acc_cpu u0 (.clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc(pc), .mar(mar), .mdr(mdr), .ir(ir), .acc(acc), .step(step), .halted(halted), .carry(carry));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mem();
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      ld_en = 1'b1; ld_addr = 5'(i); ld_data = m[i];
      tick(1);
    end
    ld_en = 1'b0;
    ma = 8'd0; mc = 1'b0;
  endtask

  task automatic model(input logic [7:0] w);
    logic [8:0] s;
    case (w[7:5])
      3'b101: ma = m[w[4:0]];
      3'b001: begin s = {1'b0, ma} + {1'b0, m[w[4:0]]}; ma = s[7:0]; mc = s[8]; end
      3'b010: m[w[4:0]] = ma;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] rand_op();
    logic [2:0] ops [6] = '{3'b101, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
    return {ops[$urandom_range(5)], 5'($urandom_range(31, 17))};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    for (int i = 1; i <= 5; i++) m[i] = 8'b011_00000;
    m[6] = 8'b101_01111; m[7] = 8'b001_10010; m[8] = 8'b010_10100;
    m[9] = 8'b001_10100; m[10] = 8'b001_10101; m[11] = 8'h00;
    m[15] = 8'd10; m[18] = 8'd71; m[21] = 8'd200;
    load_mem();
    chk("R1 pc", pc, 0); chk("R1 acc", acc, 0); chk("R1 mdr", mdr, 0);
    chk("R1 step", step, 0); chk("R1 halted", halted, 0); chk("R1 carry", carry, 0);
    rst = 1'b0;
    tick(1); chk("R3 pc inc", pc, 1); chk("R3 step", step, 1);
    tick(1); chk("R3 mar<=pc", mar, 1);
    tick(1); chk("R3 mdr<=mem", mdr, 8'h60);
    tick(1); chk("R3 ir<=mdr", ir, 8'h60);
    tick(1); chk("R4 mar<=addr", mar, 0);
    tick(2); chk("R4 step wrap", step, 0);
    tick(28); chk("R9 nop acc", acc, 0); chk("R9 nop pc", pc, 5);
    tick(7); chk("R5 load acc", acc, 10); chk("R5 mar", mar, 15); chk("R5 carry", carry, 0);
    tick(2);
    ld_en = 1'b1; ld_addr = 5'd18; ld_data = 8'd0;
    tick(1); ld_en = 1'b0;
    tick(4); chk("R6 add acc", acc, 81); chk("R2 write ignored", acc, 81); chk("R6 carry", carry, 0);
    tick(6); chk("R7 mdr<=acc", mdr, 81);
    tick(1);
    tick(7); chk("R7 stored word", acc, 162);
    tick(7); chk("R6 wrap acc", acc, 106); chk("R6 wrap carry", carry, 1);
    tick(5); chk("R8 halted", halted, 1); chk("R8 step", step, 7); chk("R8 pc", pc, 11);
    tick(10); chk("R8 pc frozen", pc, 11); chk("R8 acc frozen", acc, 106); chk("R8 step frozen", step, 7);

    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 32; i++) m[i] = 8'($urandom);
      for (int i = 1; i <= 15; i++) m[i] = rand_op();
      m[16] = 8'h00;
      load_mem();
      chk("R1 random reset acc", acc, 0);
      rst = 1'b0;
      for (int k = 1; k <= 15; k++) begin
        tick(7);
        model(m[k]);
        chk("R5 R6 R7 R9 random acc", acc, ma);
        chk("R6 random carry", carry, mc);
        chk("R4 random pc", pc, k);
      end
      tick(5); chk("R8 random halt", halted, 1); chk("R8 random pc", pc, 16);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule